// File: doc/BRIEF.md
# Lane-Partitioned Unsigned Comparator and Select

This block compares two 16-bit words as a set of independent unsigned lanes whose boundaries are chosen at run time. The word is viewed as four 4-bit nibbles, and a boundary control vector says where one lane stops and the next begins. Setting every boundary gives four 4-bit lanes. Setting only the middle boundary gives two 8-bit lanes. Clearing them all gives one 16-bit lane. Other patterns give lanes of unequal size.

For each lane, the block produces all six unsigned relations at the same time: equal, not-equal, less, less-or-equal, greater and greater-or-equal. Each relation comes out as a 4-bit vector with one bit per nibble. A lane's single result bit sits at the index of its lowest nibble, so the layout of the outputs follows the partition setting.

The same lane map drives a per-lane 2:1 select. Each lane is taken whole from `a_i` or from `b_i`. The block is purely combinational.

Top module: `lane_cmp`

## Requirements
- R1: `brk_i[i]` = 1 places a lane boundary between nibble i (bits 4i+3..4i) and nibble i+1. Nibble 0 always starts a lane. 3'b000 gives one 16-bit lane, 3'b010 gives two 8-bit lanes and 3'b111 gives four 4-bit lanes.
- R2: `eq_o` and `ne_o` report whether the lane's bits of `a_i` and `b_i` are equal or unequal.
- R3: `lt_o` and `le_o` report a-lane < b-lane and a-lane <= b-lane, compared as unsigned numbers.
- R4: `gt_o` and `ge_o` report a-lane > b-lane and a-lane >= b-lane, compared as unsigned numbers.
- R5: A lane's result bit is placed at the index of the lane's lowest nibble. For 8-bit lanes these are bits 0 and 2, and for the 16-bit lane it is bit 0.
- R6: In every predicate output, each bit whose nibble does not start a lane reads 0.
- R7: Inside a merged lane, a more significant nibble decides the relation ahead of any less significant nibble.
- R8: `mux_o` takes a lane's bits from `a_i` when the select bit at that lane's lowest nibble is 1, and from `b_i` otherwise.
- R9: Select bits at nibbles that do not start a lane have no effect on `mux_o`.
- R10: Boundary patterns that give unequal lanes, such as 3'b001 (a 4-bit lane and a 12-bit lane), compare and select each lane independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| brk_i | input | 3 | Lane boundary control, one bit per internal nibble boundary |
| sel_i | input | 4 | Per-nibble select; only the bits at lane-start nibbles are used |
| eq_o | output | 4 | Lane equal, at lane-start bit positions |
| ne_o | output | 4 | Lane not-equal |
| lt_o | output | 4 | Lane unsigned less-than |
| le_o | output | 4 | Lane unsigned less-or-equal |
| gt_o | output | 4 | Lane unsigned greater-than |
| ge_o | output | 4 | Lane unsigned greater-or-equal |
| mux_o | output | 16 | Per-lane selection of a_i or b_i |

## Verification
Operand pairs are chosen so that adjacent nibbles disagree in opposite directions, for example a low nibble smaller while the upper nibble is larger. Under each lane setting, such a pair shows whether the more significant nibble dominates and whether a lane leaks into its neighbour. All-ones against all-zero pairs are run under every setting to show that only lane-start bits can ever assert. Select vectors that set only the non-start bits separate correct lane-select lookup from per-nibble selection. A pseudo-random sweep over all eight boundary patterns, including the unequal ones, is checked against a lane-by-lane model.

// File: rtl/lane_cmp_pkg.sv
package lane_cmp_pkg;
  // default geometry of the comparator
  localparam int DEF_NIB_W   = 4;
  localparam int DEF_NUM_NIB = 4;

  // per-nibble relation of a versus b
  typedef struct packed {
    logic eq;
    logic gt;
  } nib_rel_t;
endpackage

// File: rtl/lane_nibble_cmp.sv
module lane_nibble_cmp
  import lane_cmp_pkg::*;
#(
  parameter int NIB_W   = DEF_NIB_W,
  parameter int NUM_NIB = DEF_NUM_NIB
) (
  input  logic [NIB_W*NUM_NIB-1:0] a_i,
  input  logic [NIB_W*NUM_NIB-1:0] b_i,
  output logic [NUM_NIB-1:0]       eq_o,
  output logic [NUM_NIB-1:0]       gt_o
);
  for (genvar i = 0; i < NUM_NIB; i++) begin : g_nib
    nib_rel_t rel;
    always_comb begin
      rel.eq = (a_i[i*NIB_W +: NIB_W] == b_i[i*NIB_W +: NIB_W]);
      rel.gt = (a_i[i*NIB_W +: NIB_W] >  b_i[i*NIB_W +: NIB_W]);
    end
    assign eq_o[i] = rel.eq;
    assign gt_o[i] = rel.gt;
  end
endmodule

// File: rtl/lane_cascade.sv
module lane_cascade #(
  parameter int NUM_NIB = 4
) (
  input  logic [NUM_NIB-1:0] nib_eq_i,
  input  logic [NUM_NIB-1:0] nib_gt_i,
  input  logic [NUM_NIB-2:0] brk_i,
  output logic [NUM_NIB-1:0] acc_eq_o,
  output logic [NUM_NIB-1:0] acc_gt_o
);
  // accumulate from the top nibble of each lane downward;
  // the value at a lane-start nibble covers the whole lane
  for (genvar i = 0; i < NUM_NIB; i++) begin : g_n
    logic ceq;
    logic cgt;
    if (i == NUM_NIB-1) begin : g_top
      assign ceq = nib_eq_i[i];
      assign cgt = nib_gt_i[i];
    end else begin : g_mid
      assign ceq = brk_i[i] ? nib_eq_i[i] : (g_n[i+1].ceq & nib_eq_i[i]);
      assign cgt = brk_i[i] ? nib_gt_i[i]
                            : (g_n[i+1].cgt | (g_n[i+1].ceq & nib_gt_i[i]));
    end
    assign acc_eq_o[i] = ceq;
    assign acc_gt_o[i] = cgt;
  end
endmodule

// File: rtl/lane_select.sv
module lane_select #(
  parameter int NIB_W   = 4,
  parameter int NUM_NIB = 4
) (
  input  logic [NIB_W*NUM_NIB-1:0] a_i,
  input  logic [NIB_W*NUM_NIB-1:0] b_i,
  input  logic [NUM_NIB-2:0]       brk_i,
  input  logic [NUM_NIB-1:0]       sel_i,
  output logic [NIB_W*NUM_NIB-1:0] mux_o
);
  // each nibble inherits the select bit of the nibble that opens its lane
  for (genvar i = 0; i < NUM_NIB; i++) begin : g_n
    logic lsel;
    if (i == 0) begin : g_first
      assign lsel = sel_i[0];
    end else begin : g_rest
      assign lsel = brk_i[i-1] ? sel_i[i] : g_n[i-1].lsel;
    end
    assign mux_o[i*NIB_W +: NIB_W] = lsel ? a_i[i*NIB_W +: NIB_W]
                                          : b_i[i*NIB_W +: NIB_W];
  end
endmodule

// File: rtl/lane_cmp.sv
module lane_cmp
  import lane_cmp_pkg::*;
#(
  parameter int NIB_W   = DEF_NIB_W,
  parameter int NUM_NIB = DEF_NUM_NIB
) (
  input  logic [NIB_W*NUM_NIB-1:0] a_i,
  input  logic [NIB_W*NUM_NIB-1:0] b_i,
  input  logic [NUM_NIB-2:0]       brk_i,
  input  logic [NUM_NIB-1:0]       sel_i,
  output logic [NUM_NIB-1:0]       eq_o,
  output logic [NUM_NIB-1:0]       ne_o,
  output logic [NUM_NIB-1:0]       lt_o,
  output logic [NUM_NIB-1:0]       le_o,
  output logic [NUM_NIB-1:0]       gt_o,
  output logic [NUM_NIB-1:0]       ge_o,
  output logic [NIB_W*NUM_NIB-1:0] mux_o
);
  logic [NUM_NIB-1:0] nib_eq;
  logic [NUM_NIB-1:0] nib_gt;
  logic [NUM_NIB-1:0] acc_eq;
  logic [NUM_NIB-1:0] acc_gt;
  logic [NUM_NIB-1:0] lane_start;

  lane_nibble_cmp #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) u_nib (
    .a_i  (a_i),
    .b_i  (b_i),
    .eq_o (nib_eq),
    .gt_o (nib_gt)
  );

  lane_cascade #(.NUM_NIB(NUM_NIB)) u_casc (
    .nib_eq_i (nib_eq),
    .nib_gt_i (nib_gt),
    .brk_i    (brk_i),
    .acc_eq_o (acc_eq),
    .acc_gt_o (acc_gt)
  );

  lane_select #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) u_sel (
    .a_i   (a_i),
    .b_i   (b_i),
    .brk_i (brk_i),
    .sel_i (sel_i),
    .mux_o (mux_o)
  );

  // nibble 0 always opens a lane; a boundary opens the next one
  assign lane_start = {brk_i, 1'b1};

  always_comb begin
    eq_o = lane_start &  acc_eq;
    ne_o = lane_start & ~acc_eq;
    gt_o = lane_start &  acc_gt;
    lt_o = lane_start & ~acc_gt & ~acc_eq;
    le_o = lane_start & ~acc_gt;
    ge_o = lane_start & (acc_gt | acc_eq);
  end
endmodule

// File: rtl/lane_cmp_chk.sv
module lane_cmp_chk #(
  parameter int NIB_W   = 4,
  parameter int NUM_NIB = 4
) (
  input logic [NIB_W*NUM_NIB-1:0] a_i,
  input logic [NIB_W*NUM_NIB-1:0] b_i,
  input logic [NUM_NIB-2:0]       brk_i,
  input logic [NUM_NIB-1:0]       sel_i,
  input logic [NUM_NIB-1:0]       eq_o,
  input logic [NUM_NIB-1:0]       ne_o,
  input logic [NUM_NIB-1:0]       lt_o,
  input logic [NUM_NIB-1:0]       le_o,
  input logic [NUM_NIB-1:0]       gt_o,
  input logic [NUM_NIB-1:0]       ge_o,
  input logic [NIB_W*NUM_NIB-1:0] mux_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i, brk_i, sel_i})) begin
      for (int i = 1; i < NUM_NIB; i++) begin
        if (!brk_i[i-1]) begin
          // R6
          nonstart_zero_chk: assert ({eq_o[i], ne_o[i], lt_o[i],
                                      le_o[i], gt_o[i], ge_o[i]} == 6'b0);
        end
      end
      if (&brk_i) begin
        for (int i = 0; i < NUM_NIB; i++) begin
          // R2
          nib_lane_eq_chk: assert (eq_o[i] ==
            (a_i[i*NIB_W +: NIB_W] == b_i[i*NIB_W +: NIB_W]));
        end
      end
      if (brk_i == '0) begin
        // R4
        full_gt_chk: assert (gt_o[0] == (a_i > b_i));
        // R3
        full_lt_chk: assert (lt_o[0] == (a_i < b_i));
        // R8
        full_mux_chk: assert (mux_o == (sel_i[0] ? a_i : b_i));
      end
    end
  end
endmodule

bind lane_cmp lane_cmp_chk #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) u_chk (.*);

// File: tb/lane_cmp_bench.sv
module lane_cmp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic [15:0] a, b, mux;
  logic [2:0]  brk;
  logic [3:0]  sel, eq, ne, lt, le, gt, ge;
  int          checks;
  int          fails;
  logic        done;

  lane_cmp u_lane_cmp (
    .a_i(a), .b_i(b), .brk_i(brk), .sel_i(sel),
    .eq_o(eq), .ne_o(ne), .lt_o(lt), .le_o(le),
    .gt_o(gt), .ge_o(ge), .mux_o(mux)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [2:0]  brk;
    logic [15:0] a;
    logic [15:0] b;
    logic [3:0]  sel;
    logic [3:0]  eq;
    logic [3:0]  lt;
    logic [3:0]  gt;
    logic [15:0] mux;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{3'b000, 16'h0000, 16'h0000, 4'b0001, 4'b0001, 4'b0000, 4'b0000, 16'h0000},
    '{3'b000, 16'h1234, 16'h1235, 4'b0000, 4'b0000, 4'b0001, 4'b0000, 16'h1235},
    '{3'b000, 16'h8000, 16'h7FFF, 4'b0001, 4'b0000, 4'b0000, 4'b0001, 16'h8000},
    '{3'b010, 16'h0F10, 16'h100F, 4'b0100, 4'b0000, 4'b0100, 4'b0001, 16'h0F0F},
    '{3'b010, 16'hABCD, 16'hABCD, 4'b1011, 4'b0101, 4'b0000, 4'b0000, 16'hABCD},
    '{3'b111, 16'h1F3A, 16'h2F1A, 4'b1010, 4'b0101, 4'b1000, 4'b0010, 16'h1F3A},
    '{3'b001, 16'h0015, 16'h0026, 4'b0010, 4'b0000, 4'b0011, 4'b0000, 16'h0016},
    '{3'b010, 16'hFFFF, 16'h0000, 4'b1010, 4'b0000, 4'b0000, 4'b0101, 16'h0000},
    '{3'b000, 16'hFFFF, 16'h0000, 4'b1110, 4'b0000, 4'b0000, 4'b0001, 16'h0000},
    '{3'b111, 16'h0000, 16'hFFFF, 4'b1111, 4'b0000, 4'b1111, 4'b0000, 16'h0000}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (brk=%b a=%h b=%h sel=%b)",
               tag, act, exp, brk, a, b, sel);
    end
  endtask

  task automatic apply(input logic [2:0] k, input logic [15:0] va,
                       input logic [15:0] vb, input logic [3:0] vs);
    @(posedge clk);
    brk = k; a = va; b = vb; sel = vs;
    @(negedge clk);
  endtask

  // lane-by-lane reference built from the requirements
  task automatic model(input logic [2:0] k, input logic [15:0] va,
                       input logic [15:0] vb, input logic [3:0] vs,
                       output logic [3:0] xeq, output logic [3:0] xlt,
                       output logic [3:0] xgt, output logic [15:0] xmux);
    logic [3:0] st;
    st = {k, 1'b1};
    xeq = '0; xlt = '0; xgt = '0; xmux = '0;
    for (int s = 0; s < 4; s++) begin
      if (st[s]) begin
        int e;
        logic [15:0] m;
        e = s;
        while (e < 3 && !k[e]) e++;
        m = '0;
        for (int n = s; n <= e; n++) m[n*4 +: 4] = 4'hF;
        if ((va & m) == (vb & m)) xeq[s] = 1'b1;
        if ((va & m) <  (vb & m)) xlt[s] = 1'b1;
        if ((va & m) >  (vb & m)) xgt[s] = 1'b1;
        xmux = xmux | (vs[s] ? (va & m) : (vb & m));
      end
    end
  endtask

  task automatic check_all(input string tag, input logic [3:0] xeq,
                           input logic [3:0] xlt, input logic [3:0] xgt,
                           input logic [15:0] xmux);
    logic [3:0] st;
    st = {brk, 1'b1};
    chk({tag, " R2 eq"}, {12'h0, eq}, {12'h0, xeq});
    chk({tag, " R2 ne"}, {12'h0, ne}, {12'h0, st & ~xeq});
    chk({tag, " R3 lt"}, {12'h0, lt}, {12'h0, xlt});
    chk({tag, " R3 le"}, {12'h0, le}, {12'h0, st & ~xgt});
    chk({tag, " R4 gt"}, {12'h0, gt}, {12'h0, xgt});
    chk({tag, " R4 ge"}, {12'h0, ge}, {12'h0, st & ~xlt});
    chk({tag, " R8 mux"}, mux, xmux);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0;
    a = '0; b = '0; brk = '0; sel = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state: zero inputs, single lane, equal
    chk("R5 reset eq", {12'h0, eq}, 16'h0001);
    chk("R6 reset lt", {12'h0, lt}, 16'h0000);
    chk("R8 reset mux", mux, 16'h0000);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      apply(VECS[v].brk, VECS[v].a, VECS[v].b, VECS[v].sel);
      check_all($sformatf("vec%0d", v), VECS[v].eq, VECS[v].lt, VECS[v].gt, VECS[v].mux);
    end

    // R1: same data, lane setting changes the result layout
    apply(3'b111, 16'h1234, 16'h1234, 4'b0000);
    chk("R1 four lanes eq", {12'h0, eq}, 16'h000F);
    apply(3'b000, 16'h1234, 16'h1234, 4'b0000);
    chk("R1 one lane eq", {12'h0, eq}, 16'h0001);

    // R5: two 8-bit lanes report at bits 0 and 2
    apply(3'b010, 16'h5500, 16'h5500, 4'b0000);
    chk("R5 half lanes eq", {12'h0, eq}, 16'h0005);

    // R6: non-start bits zero in every output
    apply(3'b010, 16'hFFFF, 16'h0000, 4'b0000);
    chk("R6 nonstart bits",
        {8'h0, (eq | ne | lt | le | gt | ge) & 4'b1010}, 16'h0000);
    chk("R6 ne at starts", {12'h0, ne}, 16'h0005);

    // R7: upper nibble dominates a smaller-looking low part
    apply(3'b000, 16'h1000, 16'h0FFF, 4'b0000);
    chk("R7 gt top nibble", {12'h0, gt}, 16'h0001);
    chk("R7 lt top nibble", {12'h0, lt}, 16'h0000);

    // R9: select bits at non-start nibbles ignored
    apply(3'b010, 16'hAAAA, 16'h5555, 4'b1010);
    chk("R9 nonstart sel set", mux, 16'h5555);
    apply(3'b010, 16'hAAAA, 16'h5555, 4'b0101);
    chk("R9 start sel set", mux, 16'hAAAA);

    // R10: unequal lanes, nibble 0 alone and a 12-bit upper lane
    apply(3'b001, 16'h0100, 16'h00F0, 4'b0000);
    chk("R10 uneven eq", {12'h0, eq}, 16'h0001);
    chk("R10 uneven gt", {12'h0, gt}, 16'h0002);

    // sweep all boundary patterns against the lane model
    begin
      logic [15:0] lf;
      logic [3:0]  xe, xl, xg;
      logic [15:0] xm;
      lf = 16'hACE1;
      for (int k = 0; k < 8; k++) begin
        for (int it = 0; it < 24; it++) begin
          logic [15:0] va, vb;
          lf = lf ^ (lf << 7); lf = lf ^ (lf >> 9); lf = lf ^ (lf << 8);
          va = lf;
          lf = lf ^ (lf << 7); lf = lf ^ (lf >> 9); lf = lf ^ (lf << 8);
          vb = (it % 3 == 0) ? (va ^ (16'h1 << (it % 16))) : lf;
          apply(k[2:0], va, vb, lf[3:0]);
          model(k[2:0], va, vb, lf[3:0], xe, xl, xg, xm);
          check_all($sformatf("R10 sweep brk=%0d", k), xe, xl, xg, xm);
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule